// File: doc/BRIEF.md
# LIN Frame Header Engine

This block handles the start of a frame for one channel of a LIN-style single-wire serial bus. In the master role it sends a complete header: a dominant break of programmable length, a recessive delimiter of one to four bit periods, the sync byte 0x55, and a protected identifier byte. On request it can also send a dominant wakeup pulse. In the slave role it does not transmit. Instead it cleans up the received line with an optional three-sample majority vote, qualifies a long dominant period as a break, checks that the next byte is the sync pattern, and captures the identifier together with a parity verdict.

All bit timing comes from a clock enable running at sixteen times the bit rate. One bit period is sixteen enabled cycles. Received bits are sampled at the middle of the bit, timed from the falling edge that begins each frame. The transceiver enable output is either driven by the block while the channel is on, or passed through from a host-written bit.

Top module: `linhdr_top`

## Requirements
- R1: In master mode a `sendHdr` pulse makes `txLine` go low for (cfgBreakLen+1) bit periods, where one bit period is 16 cycles in which `tick16` is high and cfgBreakLen is 0 to 31. The line goes low on the first clock edge after the pulse is sampled.
- R2: After the break, `txLine` stays high for (cfgDelimLen+1) bit periods, so the codes 0, 1, 2 and 3 select 1, 2, 3 and 4 bits.
- R3: After the delimiter, the block sends two byte frames: the sync byte 0x55 and then the protected identifier {P1,P0,id}. The id is sampled on the cycle `sendHdr` is accepted. P0 = id0^id1^id2^id4 and P1 = ~(id1^id3^id4^id5). Each frame is a low start bit, eight data bits LSB first, and one stop bit (cfgTwoStop=0) or two stop bits (cfgTwoStop=1). `txDone` pulses for one cycle on the first cycle after the last stop bit, and on that cycle `busy` is low and the line is high.
- R4: In master mode a `sendWake` pulse drives `txLine` low for (cfgBreakLen+1) bit periods, then releases it and pulses `txDone`. If `sendWake` and `sendHdr` arrive together, the wakeup wins.
- R5: In slave mode a dominant period is accepted as a break, and `breakSeen` pulses, only if the line is still low at the middle of bit cfgBreakLen counted from the falling edge, that is, low for at least cfgBreakLen+1 bit periods. A shorter dominant period yields no break and no frame.
- R6: After a break, if the first received byte is not 0x55, `syncErr` pulses and no `rxDone` follows.
- R7: After a good sync byte, the second byte's low six bits appear on `rxId` and `rxDone` pulses. `parityErr` pulses together with `rxDone` exactly when the received top two bits differ from the parity given in R3. The cfgDelimLen setting has no effect on reception.
- R8: With cfgFilterEn=1, the received value is the majority of the last three `tick16` samples, so a single low sample on an idle line starts nothing. With cfgFilterEn=0, the latest sample is used directly, and a single low sample starts break qualification (`busy` goes high).
- R9: A master never reacts to `rxLine`. A slave ignores `sendHdr` and `sendWake` and keeps `txLine` high.
- R10: `xcvrEn` equals `chanEn` when cfgAutoEn=1, and equals `hostXcvrEn` when cfgAutoEn=0.
- R11: While idle, `txLine` is high. Dropping `chanEn` returns the engine to idle on the next clock edge, with `busy` low and `txLine` high.
- R12: Timing advances only on cycles with `tick16` high. With `tick16` held low, an ongoing break holds the line low indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | Clock enable at 16x the bit rate |
| chanEn | input | 1 | Channel active |
| cfgMaster | input | 1 | 1 = master role, 0 = slave role |
| cfgAutoEn | input | 1 | 1 = block drives the transceiver enable |
| hostXcvrEn | input | 1 | Host transceiver enable bit used when cfgAutoEn=0 |
| cfgBreakLen | input | 5 | Break and wakeup length in bit periods minus one |
| cfgDelimLen | input | 2 | Delimiter length in bit periods minus one |
| cfgTwoStop | input | 1 | 1 = two stop bits per transmitted byte |
| cfgFilterEn | input | 1 | 1 = three-sample majority filter on the receive line |
| sendHdr | input | 1 | Strobe: start a header (master) |
| sendWake | input | 1 | Strobe: start a wakeup pulse (master) |
| hdrId | input | 6 | Identifier for the header |
| rxLine | input | 1 | Received bus level |
| txLine | output | 1 | Transmitted bus level |
| xcvrEn | output | 1 | Transceiver enable |
| busy | output | 1 | Engine not idle |
| txDone | output | 1 | Strobe: header or wakeup finished |
| breakSeen | output | 1 | Strobe: valid break received |
| rxDone | output | 1 | Strobe: identifier captured |
| rxId | output | 6 | Captured identifier |
| syncErr | output | 1 | Strobe: byte after the break was not 0x55 |
| parityErr | output | 1 | Strobe with rxDone: identifier parity mismatch |

## Verification
The bench builds the engine with its default parameters: sixteen enables per bit and a six-bit saturating bit counter. Because the enable is held high for most tests, a bit is exactly sixteen cycles. That makes the longest 32-bit break, the 4-bit delimiter and the two-stop-bit frames checkable cycle by cycle on `txLine`. The same counter width keeps a received break of exactly cfgBreakLen+1 bits distinguishable from one bit less. An alternating enable and a stalled enable exercise the clock-enable path. With those settings, a wakeup's length must double, and a break must freeze.

// File: rtl/linhdr_pkg.sv
package linhdr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TX_WAKE,
    ST_TX_BRK,
    ST_TX_DEL,
    ST_TX_BYTE,
    ST_RX_BRK,
    ST_RX_START,
    ST_RX_BYTE
  } lhState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic restart;   // clear bit timer and bit counter
    logic latchId;   // hold the protected id for later
    logic loadSync;  // load sync frame into tx shifter
    logic loadPid;   // load id frame into tx shifter
    logic shiftTx;   // advance tx shifter at bit end
    logic sampleRx;  // shift filtered rx value into rx byte
    logic capture;   // copy received id to output register
    logic driveLow;  // force dominant level
    logic frameOn;   // line follows tx shifter
  } lhCtl_s;

  function automatic logic [7:0] makePid(input logic [5:0] id);
    logic p0, p1;
    p0 = id[0] ^ id[1] ^ id[2] ^ id[4];
    p1 = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
    return {p1, p0, id};
  endfunction

endpackage

// File: rtl/linhdr_datapath.sv
module linhdr_datapath
  import linhdr_pkg::*;
#(
  parameter int OVS   = 16,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             filterEn,
  input  logic             rxLine,
  input  lhCtl_s           ctl,
  input  logic [7:0]       pidIn,
  output logic             bitEnd,
  output logic             midBit,
  output logic [CNT_W-1:0] bitCnt,
  output logic             rxF,
  output logic [7:0]       rxByte,
  output logic [5:0]       rxId,
  output logic             txLine
);
  localparam int SUB_W = $clog2(OVS);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);
  localparam logic [SUB_W-1:0] SUB_MID  = SUB_W'(OVS / 2 - 1);
  localparam int FRAME_W = 11;  // start + 8 data + up to 2 stop

  logic [SUB_W-1:0]   subCnt;
  logic [2:0]         hist;
  logic [FRAME_W-1:0] txFrame;
  logic [7:0]         pidHold;
  logic               majority;

  assign bitEnd = tick && (subCnt == SUB_LAST);
  assign midBit = tick && (subCnt == SUB_MID);

  // bit timer with a saturating bit counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      subCnt <= '0;
      bitCnt <= '0;
    end else if (ctl.restart) begin
      subCnt <= '0;
      bitCnt <= '0;
    end else if (tick) begin
      subCnt <= (subCnt == SUB_LAST) ? '0 : subCnt + 1'b1;
      if (subCnt == SUB_LAST && bitCnt != '1) bitCnt <= bitCnt + 1'b1;
    end
  end

  // three-sample receive history
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) hist <= 3'b111;
    else if (tick) hist <= {hist[1:0], rxLine};
  end

  assign majority = (hist[0] & hist[1]) | (hist[0] & hist[2]) | (hist[1] & hist[2]);
  assign rxF      = filterEn ? majority : hist[0];

  // transmit frame shifter, start bit in the LSB
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txFrame <= '1;
      pidHold <= '0;
    end else begin
      if (ctl.latchId) pidHold <= pidIn;
      if (ctl.loadSync)               txFrame <= {2'b11, 8'h55, 1'b0};
      else if (ctl.loadPid)           txFrame <= {2'b11, pidHold, 1'b0};
      else if (ctl.shiftTx && bitEnd) txFrame <= {1'b1, txFrame[FRAME_W-1:1]};
    end
  end

  // receive shifter, LSB first
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte <= '0;
      rxId   <= '0;
    end else begin
      if (ctl.sampleRx) rxByte <= {rxF, rxByte[7:1]};
      if (ctl.capture)  rxId   <= rxByte[5:0];
    end
  end

  assign txLine = ctl.driveLow ? 1'b0 : (ctl.frameOn ? txFrame[0] : 1'b1);

endmodule

// File: rtl/linhdr_control.sv
module linhdr_control
  import linhdr_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             chanEn,
  input  logic             cfgMaster,
  input  logic             sendHdr,
  input  logic             sendWake,
  input  logic [4:0]       brkLen,
  input  logic [1:0]       delimLen,
  input  logic             twoStop,
  input  logic             bitEnd,
  input  logic             midBit,
  input  logic [CNT_W-1:0] bitCnt,
  input  logic             rxF,
  input  logic [7:0]       rxByte,
  output lhCtl_s           ctl,
  output logic             busy,
  output logic             txDone,
  output logic             breakSeen,
  output logic             rxDone,
  output logic             syncErr,
  output logic             parityErr
);
  lhState_e         st, nxt;
  logic             byteSel, nxtSel;
  logic             doneN, brkN, rxDoneN, syncN, parN;
  logic [CNT_W-1:0] brkLast, delimLast, stopLast;
  logic [7:0]       pidChk;

  assign brkLast   = CNT_W'(brkLen);
  assign delimLast = CNT_W'(delimLen);
  assign stopLast  = CNT_W'(twoStop ? 10 : 9);
  assign pidChk    = makePid(rxByte[5:0]);
  assign busy      = (st != ST_IDLE);

  always_comb begin
    nxt = st;
    nxtSel = byteSel;
    ctl = '0;
    doneN = 1'b0; brkN = 1'b0; rxDoneN = 1'b0; syncN = 1'b0; parN = 1'b0;
    case (st)
      ST_IDLE: begin
        if (cfgMaster) begin
          if (sendWake) begin
            nxt = ST_TX_WAKE; ctl.restart = 1'b1;
          end else if (sendHdr) begin
            nxt = ST_TX_BRK; ctl.restart = 1'b1; ctl.latchId = 1'b1;
          end
        end else if (!rxF) begin
          nxt = ST_RX_BRK; ctl.restart = 1'b1;
        end
      end
      ST_TX_WAKE: begin
        ctl.driveLow = 1'b1;
        if (bitEnd && bitCnt == brkLast) begin
          nxt = ST_IDLE; doneN = 1'b1;
        end
      end
      ST_TX_BRK: begin
        ctl.driveLow = 1'b1;
        if (bitEnd && bitCnt == brkLast) begin
          nxt = ST_TX_DEL; ctl.restart = 1'b1;
        end
      end
      ST_TX_DEL: begin
        if (bitEnd && bitCnt == delimLast) begin
          nxt = ST_TX_BYTE; ctl.restart = 1'b1; ctl.loadSync = 1'b1; nxtSel = 1'b0;
        end
      end
      ST_TX_BYTE: begin
        ctl.frameOn = 1'b1;
        ctl.shiftTx = 1'b1;
        if (bitEnd && bitCnt == stopLast) begin
          if (!byteSel) begin
            ctl.restart = 1'b1; ctl.loadPid = 1'b1; nxtSel = 1'b1;
          end else begin
            nxt = ST_IDLE; doneN = 1'b1;
          end
        end
      end
      ST_RX_BRK: begin
        if (midBit && rxF) begin
          if (bitCnt > brkLast) begin
            nxt = ST_RX_START; brkN = 1'b1; nxtSel = 1'b0;
          end else begin
            nxt = ST_IDLE;
          end
        end
      end
      ST_RX_START: begin
        if (!rxF) begin
          nxt = ST_RX_BYTE; ctl.restart = 1'b1;
        end
      end
      ST_RX_BYTE: begin
        if (midBit) begin
          if (bitCnt == '0) begin
            if (rxF) nxt = ST_IDLE;  // false start bit
          end else if (bitCnt <= CNT_W'(8)) begin
            ctl.sampleRx = 1'b1;
          end else if (!byteSel) begin
            if (rxByte != 8'h55) begin
              syncN = 1'b1; nxt = ST_IDLE;
            end else begin
              nxt = ST_RX_START; nxtSel = 1'b1;
            end
          end else begin
            ctl.capture = 1'b1; rxDoneN = 1'b1;
            parN = (rxByte[7:6] != pidChk[7:6]);
            nxt = ST_IDLE;
          end
        end
      end
      default: nxt = ST_IDLE;
    endcase
    if (!chanEn) begin
      nxt = ST_IDLE;
      doneN = 1'b0; brkN = 1'b0; rxDoneN = 1'b0; syncN = 1'b0; parN = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st <= ST_IDLE;
      byteSel <= 1'b0;
      txDone <= 1'b0; breakSeen <= 1'b0; rxDone <= 1'b0;
      syncErr <= 1'b0; parityErr <= 1'b0;
    end else begin
      st <= nxt;
      byteSel <= nxtSel;
      txDone <= doneN; breakSeen <= brkN; rxDone <= rxDoneN;
      syncErr <= syncN; parityErr <= parN;
    end
  end

endmodule

// File: rtl/linhdr_top.sv
module linhdr_top
  import linhdr_pkg::*;
#(
  parameter int OVS   = 16,
  parameter int CNT_W = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick16,
  input  logic       chanEn,
  input  logic       cfgMaster,
  input  logic       cfgAutoEn,
  input  logic       hostXcvrEn,
  input  logic [4:0] cfgBreakLen,
  input  logic [1:0] cfgDelimLen,
  input  logic       cfgTwoStop,
  input  logic       cfgFilterEn,
  input  logic       sendHdr,
  input  logic       sendWake,
  input  logic [5:0] hdrId,
  input  logic       rxLine,
  output logic       txLine,
  output logic       xcvrEn,
  output logic       busy,
  output logic       txDone,
  output logic       breakSeen,
  output logic       rxDone,
  output logic [5:0] rxId,
  output logic       syncErr,
  output logic       parityErr
);
  lhCtl_s           ctl;
  logic             bitEnd, midBit, rxF;
  logic [CNT_W-1:0] bitCnt;
  logic [7:0]       rxByte;

  assign xcvrEn = cfgAutoEn ? chanEn : hostXcvrEn;

  linhdr_control #(.CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .chanEn(chanEn), .cfgMaster(cfgMaster),
    .sendHdr(sendHdr), .sendWake(sendWake), .brkLen(cfgBreakLen),
    .delimLen(cfgDelimLen), .twoStop(cfgTwoStop), .bitEnd(bitEnd),
    .midBit(midBit), .bitCnt(bitCnt), .rxF(rxF), .rxByte(rxByte),
    .ctl(ctl), .busy(busy), .txDone(txDone), .breakSeen(breakSeen),
    .rxDone(rxDone), .syncErr(syncErr), .parityErr(parityErr)
  );

  linhdr_datapath #(.OVS(OVS), .CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .tick(tick16), .filterEn(cfgFilterEn),
    .rxLine(rxLine), .ctl(ctl), .pidIn(makePid(hdrId)), .bitEnd(bitEnd),
    .midBit(midBit), .bitCnt(bitCnt), .rxF(rxF), .rxByte(rxByte),
    .rxId(rxId), .txLine(txLine)
  );

endmodule

// File: rtl/linhdr_checker.sv
module linhdr_checker (
  input logic clk,
  input logic rstN,
  input logic chanEn,
  input logic busy,
  input logic txLine,
  input logic txDone,
  input logic rxDone,
  input logic syncErr,
  input logic parityErr
);
  // R11
  idle_recessive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> txLine);

  // R11
  chan_off_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !chanEn |=> !busy);

  // R3
  done_released_chk: assert property (@(posedge clk) disable iff (!rstN)
    txDone |-> (!busy && txLine));

  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({txDone, rxDone, syncErr}));

  // R7
  parity_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    parityErr |-> rxDone);
endmodule

bind linhdr_top linhdr_checker chk_i (
  .clk(clk), .rstN(rstN), .chanEn(chanEn), .busy(busy), .txLine(txLine),
  .txDone(txDone), .rxDone(rxDone), .syncErr(syncErr), .parityErr(parityErr)
);

// File: tb/linhdr_top_tb_top.sv
module linhdr_top_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick16 = 1'b1;
  logic chanEn = 1'b1, cfgMaster = 1'b1, cfgAutoEn = 1'b1, hostXcvrEn = 1'b0;
  logic [4:0] cfgBreakLen = 5'd13;
  logic [1:0] cfgDelimLen = 2'd0;
  logic cfgTwoStop = 1'b0, cfgFilterEn = 1'b1;
  logic sendHdr = 1'b0, sendWake = 1'b0;
  logic [5:0] hdrId = '0;
  logic rxLine = 1'b1;
  logic txLine, xcvrEn, busy, txDone, breakSeen, rxDone, syncErr, parityErr;
  logic [5:0] rxId;

  int nChecks = 0, nFail = 0;
  int tickMode = 0;  // 0 every cycle, 1 alternate, 2 stalled
  int nBrk = 0, nDone = 0, nSync = 0, nPar = 0;
  logic [5:0] lastId = '0;
  logic capTx [0:2047];
  logic capDone [0:2047];

  always #2.5 clk = ~clk;

  linhdr_top dut_i (
    .clk(clk), .rstN(rstN), .tick16(tick16), .chanEn(chanEn),
    .cfgMaster(cfgMaster), .cfgAutoEn(cfgAutoEn), .hostXcvrEn(hostXcvrEn),
    .cfgBreakLen(cfgBreakLen), .cfgDelimLen(cfgDelimLen),
    .cfgTwoStop(cfgTwoStop), .cfgFilterEn(cfgFilterEn), .sendHdr(sendHdr),
    .sendWake(sendWake), .hdrId(hdrId), .rxLine(rxLine), .txLine(txLine),
    .xcvrEn(xcvrEn), .busy(busy), .txDone(txDone), .breakSeen(breakSeen),
    .rxDone(rxDone), .rxId(rxId), .syncErr(syncErr), .parityErr(parityErr)
  );

  initial begin
    forever begin
      @(negedge clk);
      case (tickMode)
        0: tick16 = 1'b1;
        1: tick16 = ~tick16;
        default: tick16 = 1'b0;
      endcase
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (breakSeen) nBrk++;
      if (syncErr) nSync++;
      if (rxDone) begin
        nDone++;
        lastId = rxId;
        if (parityErr) nPar++;
      end
    end
  end

  function automatic logic [7:0] benchPid(input logic [5:0] id);
    logic p0, p1;
    p0 = id[0] ^ id[1] ^ id[2] ^ id[4];
    p1 = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
    return {p1, p0, id};
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
  endtask

  function automatic logic expAt(input int i, input int s1, input int s2,
                                 input int fl, input logic [7:0] pid);
    int j, k;
    logic [7:0] by;
    if (i < s1) return 1'b0;
    if (i < s2) return 1'b1;
    j = i - s2;
    if (j >= 2 * fl) return 1'b1;
    by = (j < fl) ? 8'h55 : pid;
    k = (j % fl) / 16;
    if (k == 0) return 1'b0;
    if (k <= 8) return by[k-1];
    return 1'b1;
  endfunction

  task automatic clearCounts;
    nBrk = 0; nDone = 0; nSync = 0; nPar = 0;
  endtask

  task automatic testReset;
    @(negedge clk);
    chk("R11", "txLine in reset", int'(txLine), 1);
    chk("R11", "busy in reset", int'(busy), 0);
    chk("R10", "xcvrEn auto in reset", int'(xcvrEn), 1);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11", "txLine idle", int'(txLine), 1);
    chk("R3", "txDone idle", int'(txDone), 0);
  endtask

  // R1 R2 R3
  task automatic testHeader(input logic [5:0] id, input int b, input int d, input bit two);
    int s1, s2, fl, s4, m1, m2, m3, m4, mt, dn;
    logic [7:0] pid;
    cfgMaster = 1'b1; cfgBreakLen = 5'(b); cfgDelimLen = 2'(d); cfgTwoStop = two;
    hdrId = id;
    pid = benchPid(id);
    s1 = (b + 1) * 16;
    s2 = s1 + (d + 1) * 16;
    fl = (two ? 11 : 10) * 16;
    s4 = s2 + 2 * fl;
    @(negedge clk); sendHdr = 1'b1;
    @(negedge clk); sendHdr = 1'b0; hdrId = ~id;
    for (int i = 0; i < s4 + 32; i++) begin
      capTx[i] = txLine;
      capDone[i] = txDone;
      @(negedge clk);
    end
    m1 = 0; m2 = 0; m3 = 0; m4 = 0; mt = 0; dn = 0;
    for (int i = 0; i < s4 + 32; i++) begin
      if (capTx[i] !== expAt(i, s1, s2, fl, pid)) begin
        if (i < s1) m1++;
        else if (i < s2) m2++;
        else if (i < s2 + fl) m3++;
        else if (i < s4) m4++;
        else mt++;
      end
      if (capDone[i] === 1'b1 && i != s4) dn++;
    end
    chk("R1", $sformatf("break cycles wrong (b=%0d)", b), m1, 0);
    chk("R2", $sformatf("delimiter cycles wrong (d=%0d)", d), m2, 0);
    chk("R3", "sync frame cycles wrong", m3, 0);
    chk("R3", $sformatf("pid frame cycles wrong (id=%0d)", id), m4, 0);
    chk("R3", "line after header", mt, 0);
    chk("R3", "txDone at end", int'(capDone[s4]), 1);
    chk("R3", "stray txDone", dn, 0);
  endtask

  // R4 R12
  task automatic testWake(input int b, input int mode);
    int n;
    tickMode = mode;
    cfgMaster = 1'b1; cfgBreakLen = 5'(b);
    repeat (3) @(negedge clk);
    sendWake = 1'b1; sendHdr = 1'b1;
    @(negedge clk); sendWake = 1'b0; sendHdr = 1'b0;
    n = 0;
    while (txLine == 1'b0 && n < 5000) begin
      n++;
      @(negedge clk);
    end
    chk("R4", "txDone at wake end", int'(txDone), 1);
    if (mode == 0) chk("R4", "wake low cycles", n, (b + 1) * 16);
    else chk("R12", "wake low cycles at half tick rate in range",
             int'(n == (b + 1) * 32 || n == (b + 1) * 32 - 1), 1);
    repeat (40) @(negedge clk);
    chk("R4", "no delimiter or byte after wake", int'(txLine), 1);
    tickMode = 0;
  endtask

  // R12 R11 R10
  task automatic testStallAbort;
    cfgMaster = 1'b1; cfgBreakLen = 5'd2;
    @(negedge clk); tickMode = 2; sendHdr = 1'b1;
    @(negedge clk); sendHdr = 1'b0;
    repeat (300) @(negedge clk);
    chk("R12", "break frozen without tick", int'(txLine), 0);
    chk("R12", "busy while frozen", int'(busy), 1);
    chanEn = 1'b0;
    @(negedge clk);
    chk("R11", "busy after chanEn drop", int'(busy), 0);
    chk("R11", "txLine after chanEn drop", int'(txLine), 1);
    chk("R10", "xcvrEn follows chanEn", int'(xcvrEn), 0);
    cfgAutoEn = 1'b0; hostXcvrEn = 1'b1;
    @(negedge clk);
    chk("R10", "xcvrEn follows host bit", int'(xcvrEn), 1);
    hostXcvrEn = 1'b0;
    @(negedge clk);
    chk("R10", "xcvrEn host bit low", int'(xcvrEn), 0);
    cfgAutoEn = 1'b1; chanEn = 1'b1; tickMode = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic driveBits(input logic lvl, input int nb);
    rxLine = lvl;
    repeat (nb * 16) @(negedge clk);
  endtask

  task automatic driveFrame(input logic [7:0] by);
    driveBits(1'b0, 1);
    for (int k = 0; k < 8; k++) driveBits(by[k], 1);
    driveBits(1'b1, 1);
  endtask

  task automatic sendRx(input int brkBits, input logic [7:0] sy, input logic [7:0] pid);
    clearCounts();
    driveBits(1'b0, brkBits);
    driveBits(1'b1, 1);
    driveFrame(sy);
    driveFrame(pid);
    driveBits(1'b1, 4);
  endtask

  // R5 R6 R7
  task automatic testSlave;
    cfgMaster = 1'b0; cfgBreakLen = 5'd13; cfgDelimLen = 2'd3; cfgFilterEn = 1'b1;
    repeat (8) @(negedge clk);
    sendRx(14, 8'h55, benchPid(6'h2A));
    chk("R5", "break of exactly B+1 bits seen", nBrk, 1);
    chk("R7", "rxDone count", nDone, 1);
    chk("R7", "rxId", int'(lastId), 'h2A);
    chk("R7", "no parity error", nPar, 0);
    sendRx(13, 8'h55, benchPid(6'h11));
    chk("R5", "short break rejected", nBrk, 0);
    chk("R5", "no frame after short break", nDone, 0);
    sendRx(14, 8'h54, benchPid(6'h05));
    chk("R6", "sync error count", nSync, 1);
    chk("R6", "no rxDone after bad sync", nDone, 0);
    sendRx(14, 8'h55, benchPid(6'h07) ^ 8'h80);
    chk("R7", "rxDone on bad parity", nDone, 1);
    chk("R7", "parity error flagged", nPar, 1);
    chk("R7", "rxId on bad parity", int'(lastId), 'h07);
  endtask

  // R8 R9
  task automatic testFilterRole;
    int nb;
    cfgMaster = 1'b0; cfgFilterEn = 1'b1;
    repeat (4) @(negedge clk);
    rxLine = 1'b0; @(negedge clk); rxLine = 1'b1;
    nb = 0;
    repeat (6) begin @(negedge clk); if (busy) nb++; end
    chk("R8", "filtered glitch ignored", nb, 0);
    cfgFilterEn = 1'b0;
    rxLine = 1'b0; @(negedge clk); rxLine = 1'b1;
    nb = 0;
    repeat (6) begin @(negedge clk); if (busy) nb++; end
    chk("R8", "unfiltered glitch starts break check", int'(nb > 0), 1);
    repeat (40) @(negedge clk);
    cfgFilterEn = 1'b1;
    sendHdr = 1'b1; sendWake = 1'b1;
    @(negedge clk); sendHdr = 1'b0; sendWake = 1'b0;
    nb = 0;
    repeat (100) begin @(negedge clk); if (busy || !txLine) nb++; end
    chk("R9", "slave ignores transmit requests", nb, 0);
    cfgMaster = 1'b1;
    repeat (4) @(negedge clk);
    rxLine = 1'b0;
    nb = 0;
    repeat (40 * 16) begin @(negedge clk); if (busy) nb++; end
    rxLine = 1'b1;
    chk("R9", "master ignores receive line", nb, 0);
    repeat (8) @(negedge clk);
  endtask

  initial begin
    #(150000 * 5);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    testHeader(6'h3C, 13, 0, 1'b0);
    testHeader(6'h00, 0, 3, 1'b1);
    testHeader(6'h3F, 31, 1, 1'b0);
    testWake(11, 0);
    testWake(3, 1);
    testStallAbort();
    testSlave();
    testFilterRole();
    summary();
    $finish;
  end
endmodule